// File: doc/BRIEF.md
# JTAG TAP Bus Monitor

This block listens passively on the four JTAG wires (TCK, TMS, TDI, TDO) from a faster system clock. It drives none of them. It keeps its own copy of the sixteen-state test access port controller and steps that copy on every rising TCK edge. After each step it reports the state the port has just entered. While the port stays in a shift state, the block gathers the TDI and TDO bits. When the shift ends, it hands out a single record that says which register was scanned and carries both bit vectors and the bit count.

All four wires pass through a two-stage synchronizer. A rising TCK edge is a 0 followed by a 1 on the synchronized TCK. The shadow state is named `st_*` below. It starts in Run-Test/Idle. The states are Test-Logic-Reset (TLR), Run-Test/Idle (RTI), Select-DR (SDR), Capture-DR (CDR), Shift-DR (SHDR), Exit1-DR (E1DR), Pause-DR (PDR), Exit2-DR (E2DR) and Update-DR (UDR), together with the matching IR states SIR, CIR, SHIR, E1IR, PIR, E2IR and UIR.

Records leave on a valid/ready handshake. State reports are single-cycle pulses.

Top module: `tap_bus_monitor`

## Requirements
- R1: After reset the shadow state is RTI. `st_valid` and `rec_valid` are 0 until the first TCK activity.
- R2: The shadow state moves only on a synchronized rising TCK edge. Falling TCK edges, and changes on TMS, TDI or TDO while TCK does not rise, produce no report and no record.
- R3: The transitions are written here as TMS=0 / TMS=1.
  - TLR goes to RTI / TLR.
  - RTI goes to RTI / SDR.
  - SDR goes to CDR / SIR.
  - SIR goes to CIR / TLR.
  - CDR goes to SHDR / E1DR, and CIR goes to SHIR / E1IR.
  - SHDR goes to SHDR / E1DR, and SHIR goes to SHIR / E1IR.
  - E1DR goes to PDR / UDR, and E1IR goes to PIR / UIR.
  - PDR goes to PDR / E2DR, and PIR goes to PIR / E2IR.
  - E2DR goes to SHDR / UDR, and E2IR goes to SHIR / UIR.
  - UDR and UIR both go to RTI / SDR.
- R4: Every rising TCK edge except the first after reset gives a one-cycle `st_valid` pulse. `st_code` then holds the new state, coded TLR=0, RTI=1, SDR=2, CDR=3, UDR=4, PDR=5, SHDR=6, E1DR=7, E2DR=8, SIR=9, CIR=10, UIR=11, PIR=12, SHIR=13, E1IR=14, E2IR=15.
- R5: A TDI/TDO pair is collected only on an edge whose old and new states are the same shift state. The edges that enter or leave the shift state collect nothing.
- R6: TDI and TDO are taken from the same rising edge that steps the state.
- R7: A step from SHDR to E1DR, or from SHIR to E1IR, loads a record. `rec_is_ir` is 1 for IR and 0 for DR, and the record carries the vectors and `rec_count`. A shift with no collected bits gives a record with count 0. Reaching E1DR straight from CDR gives no record.
- R8: The first collected bit lands in bit 0 of `rec_tdi` and `rec_tdo`. Each later bit takes the next higher position. Positions beyond the count read 0.
- R9: Once WIDTH bits are held, further bits are dropped, `rec_count` stays at WIDTH, and `rec_ovf` is 1 in that record.
- R10: A record stays valid and unchanged until `rec_ready` is seen high. A record that completes while an earlier one is still unaccepted is discarded.
- R11: The collectors and the counter clear when a shift ends, so each record holds only the bits of its own shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tck | input | 1 | Test clock wire (asynchronous) |
| tms | input | 1 | Test mode select wire (asynchronous) |
| tdi | input | 1 | Test data in wire (asynchronous) |
| tdo | input | 1 | Test data out wire (asynchronous) |
| st_valid | output | 1 | One-cycle state report strobe |
| st_code | output | 4 | Code of the state just entered |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record accepted when high with rec_valid |
| rec_is_ir | output | 1 | 1 = IR scan, 0 = DR scan |
| rec_tdi | output | WIDTH | Collected TDI bits, first bit in bit 0 |
| rec_tdo | output | WIDTH | Collected TDO bits, first bit in bit 0 |
| rec_count | output | $clog2(WIDTH+1) | Number of bits held |
| rec_ovf | output | 1 | Bits were dropped after the count reached WIDTH |

## Verification
The assertions rely on a few conditions at the inputs:
- Each TCK high phase and low phase lasts at least three system clocks, so no edge is lost in the synchronizer.
- TMS, TDI and TDO are settled before TCK rises.
- TCK is low when reset is released.

The stimulus follows these conditions. It holds each TCK phase for four clocks. It changes the data wires only while TCK is low, except in the deliberate wiggle test, where TCK never rises. Under these conditions a report pulse can never be followed by another in the next cycle, and a record can only appear in the same cycle as an Exit1 report.

// File: rtl/tapw_pkg.sv
package tapw_pkg;

    typedef enum logic [3:0] {
        ST_TLR  = 4'd0,
        ST_RTI  = 4'd1,
        ST_SDR  = 4'd2,
        ST_CDR  = 4'd3,
        ST_UDR  = 4'd4,
        ST_PDR  = 4'd5,
        ST_SHDR = 4'd6,
        ST_E1DR = 4'd7,
        ST_E2DR = 4'd8,
        ST_SIR  = 4'd9,
        ST_CIR  = 4'd10,
        ST_UIR  = 4'd11,
        ST_PIR  = 4'd12,
        ST_SHIR = 4'd13,
        ST_E1IR = 4'd14,
        ST_E2IR = 4'd15
    } tap_state_t;

endpackage

// File: rtl/tapw_sync.sv
module tapw_sync #(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] synced
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/tapw_fsm.sv
module tapw_fsm
    import tapw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tck_s,
    input  logic       tms_s,
    output logic       adv,
    output tap_state_t cur_st,
    output tap_state_t nxt_st,
    output logic       st_valid,
    output logic [3:0] st_code
);
    logic tck_d;
    logic armed;

    assign adv = tck_s & ~tck_d;

    always_comb begin
        unique case (cur_st)
            ST_TLR:  nxt_st = tms_s ? ST_TLR  : ST_RTI;
            ST_RTI:  nxt_st = tms_s ? ST_SDR  : ST_RTI;
            ST_SDR:  nxt_st = tms_s ? ST_SIR  : ST_CDR;
            ST_CDR:  nxt_st = tms_s ? ST_E1DR : ST_SHDR;
            ST_SHDR: nxt_st = tms_s ? ST_E1DR : ST_SHDR;
            ST_E1DR: nxt_st = tms_s ? ST_UDR  : ST_PDR;
            ST_PDR:  nxt_st = tms_s ? ST_E2DR : ST_PDR;
            ST_E2DR: nxt_st = tms_s ? ST_UDR  : ST_SHDR;
            ST_UDR:  nxt_st = tms_s ? ST_SDR  : ST_RTI;
            ST_SIR:  nxt_st = tms_s ? ST_TLR  : ST_CIR;
            ST_CIR:  nxt_st = tms_s ? ST_E1IR : ST_SHIR;
            ST_SHIR: nxt_st = tms_s ? ST_E1IR : ST_SHIR;
            ST_E1IR: nxt_st = tms_s ? ST_UIR  : ST_PIR;
            ST_PIR:  nxt_st = tms_s ? ST_E2IR : ST_PIR;
            ST_E2IR: nxt_st = tms_s ? ST_UIR  : ST_SHIR;
            ST_UIR:  nxt_st = tms_s ? ST_SDR  : ST_RTI;
            default: nxt_st = ST_RTI;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= ST_RTI;
            tck_d  <= 1'b0;
        end else begin
            tck_d <= tck_s;
            if (adv) cur_st <= nxt_st;
        end
    end

    // report outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            st_valid <= 1'b0;
            st_code  <= 4'd0;
        end else begin
            armed    <= armed | adv;
            st_valid <= adv & armed;
            if (adv) st_code <= nxt_st;
        end
    end
endmodule

// File: rtl/tapw_collect.sv
module tapw_collect
    import tapw_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int CW = $clog2(WIDTH + 1),
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  tap_state_t       cur_st,
    input  tap_state_t       nxt_st,
    input  logic             tdi_s,
    input  logic             tdo_s,
    input  logic             rec_ready,
    output logic             rec_valid,
    output logic             rec_is_ir,
    output logic [WIDTH-1:0] rec_tdi,
    output logic [WIDTH-1:0] rec_tdo,
    output logic [CW-1:0]    rec_count,
    output logic             rec_ovf
);
    localparam logic [CW-1:0] FULL = CW'(WIDTH);

    logic [WIDTH-1:0] acc_tdi, acc_tdo;
    logic [CW-1:0]    acc_cnt;
    logic             acc_ovf;
    logic             in_shift, stay, leave, load;

    assign in_shift = (cur_st == ST_SHDR) || (cur_st == ST_SHIR);
    assign stay     = adv && in_shift && (nxt_st == cur_st);
    assign leave    = adv && in_shift && (nxt_st != cur_st);
    assign load     = leave && (!rec_valid || rec_ready);

    always_ff @(posedge clk) begin
        if (!rst_n || leave) begin
            acc_tdi <= '0;
            acc_tdo <= '0;
            acc_cnt <= '0;
            acc_ovf <= 1'b0;
        end else if (stay) begin
            if (acc_cnt < FULL) begin
                acc_tdi[acc_cnt[IW-1:0]] <= tdi_s;
                acc_tdo[acc_cnt[IW-1:0]] <= tdo_s;
                acc_cnt <= acc_cnt + 1'b1;
            end else begin
                acc_ovf <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_is_ir <= 1'b0;
            rec_tdi   <= '0;
            rec_tdo   <= '0;
            rec_count <= '0;
            rec_ovf   <= 1'b0;
        end else if (load) begin
            rec_valid <= 1'b1;
            rec_is_ir <= (cur_st == ST_SHIR);
            rec_tdi   <= acc_tdi;
            rec_tdo   <= acc_tdo;
            rec_count <= acc_cnt;
            rec_ovf   <= acc_ovf;
        end else if (rec_ready) begin
            rec_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tap_bus_monitor.sv
module tap_bus_monitor
    import tapw_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck,
    input  logic             tms,
    input  logic             tdi,
    input  logic             tdo,
    output logic             st_valid,
    output logic [3:0]       st_code,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic             rec_is_ir,
    output logic [WIDTH-1:0] rec_tdi,
    output logic [WIDTH-1:0] rec_tdo,
    output logic [CW-1:0]    rec_count,
    output logic             rec_ovf
);
    logic [3:0] pins_s;
    logic       adv;
    tap_state_t cur_st, nxt_st;

    tapw_sync #(.LANES(4), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({tdo, tdi, tms, tck}),
        .synced (pins_s)
    );

    tapw_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tck_s    (pins_s[0]),
        .tms_s    (pins_s[1]),
        .adv      (adv),
        .cur_st   (cur_st),
        .nxt_st   (nxt_st),
        .st_valid (st_valid),
        .st_code  (st_code)
    );

    tapw_collect #(.WIDTH(WIDTH)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .cur_st    (cur_st),
        .nxt_st    (nxt_st),
        .tdi_s     (pins_s[2]),
        .tdo_s     (pins_s[3]),
        .rec_ready (rec_ready),
        .rec_valid (rec_valid),
        .rec_is_ir (rec_is_ir),
        .rec_tdi   (rec_tdi),
        .rec_tdo   (rec_tdo),
        .rec_count (rec_count),
        .rec_ovf   (rec_ovf)
    );
endmodule

// File: rtl/tapw_check.sv
module tapw_check #(
    parameter int WIDTH = 64,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic [3:0]       st_code,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic             rec_is_ir,
    input logic [WIDTH-1:0] rec_tdi,
    input logic [WIDTH-1:0] rec_tdo,
    input logic [CW-1:0]    rec_count,
    input logic             rec_ovf
);
    localparam logic [CW-1:0] FULL = CW'(WIDTH);

    logic [3:0] last_code;
    logic       last_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_code <= 4'd0;
            last_ok   <= 1'b0;
        end else if (st_valid) begin
            last_code <= st_code;
            last_ok   <= 1'b1;
        end
    end

    // R4: a report is a single-cycle pulse
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);

    // R9: the count never exceeds the vector width
    assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_count <= FULL));

    // R9: an overflow flag comes only with a full count
    assert_ovf_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ovf) |-> (rec_count == FULL));

    // R10: the record is held unchanged while it waits
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_tdi) && $stable(rec_tdo)
            && $stable(rec_count) && $stable(rec_is_ir) && $stable(rec_ovf)));

    // R5: a new record appears only together with an Exit1 report
    assert_record_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_valid) |-> (st_valid && (st_code == 4'd7 || st_code == 4'd14)));

    // R7: leaving a shift state with a free output loads a record of the right type
    assert_record_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && last_ok && $past(!rec_valid || rec_ready)
            && ((last_code == 4'd6 && st_code == 4'd7) || (last_code == 4'd13 && st_code == 4'd14)))
        |-> (rec_valid && (rec_is_ir == (st_code == 4'd14))));
endmodule

bind tap_bus_monitor tapw_check #(.WIDTH(WIDTH)) u_tapw_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_code   (st_code),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_is_ir (rec_is_ir),
    .rec_tdi   (rec_tdi),
    .rec_tdo   (rec_tdo),
    .rec_count (rec_count),
    .rec_ovf   (rec_ovf)
);

// File: tb/test_tap_bus_monitor.sv
module test_tap_bus_monitor;
    localparam int BW = 8;
    localparam int CW = $clog2(BW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tck = 1'b0, tms = 1'b0, tdi = 1'b0, tdo = 1'b0;
    logic rec_ready = 1'b1;
    logic st_valid, rec_valid, rec_is_ir, rec_ovf;
    logic [3:0] st_code;
    logic [BW-1:0] rec_tdi, rec_tdo;
    logic [CW-1:0] rec_count;

    always #2 clk = ~clk;

    tap_bus_monitor #(.WIDTH(BW)) i_tap_bus_monitor (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .st_valid(st_valid), .st_code(st_code), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_is_ir(rec_is_ir), .rec_tdi(rec_tdi),
        .rec_tdo(rec_tdo), .rec_count(rec_count), .rec_ovf(rec_ovf)
    );

    typedef struct {
        logic          ir;
        logic [BW-1:0] ti;
        logic [BW-1:0] to;
        int            cnt;
        logic          ovf;
    } rec_t;

    int   n_chk = 0, n_bad = 0, n_pulse = 0;
    bit   done = 0;
    int   exp_st[$];
    rec_t exp_rec[$];

    // independent reference of the port controller
    int   m_state = 1;
    bit   m_first = 1;
    logic [BW-1:0] m_ti = '0, m_to = '0;
    int   m_cnt = 0;
    logic m_ovf = 0;
    bit   stalling = 0, stall_full = 0;
    rec_t held;

    function automatic int ref_next(int s, logic t);
        case (s)
            0:  return t ? 0 : 1;
            1:  return t ? 2 : 1;
            2:  return t ? 9 : 3;
            3:  return t ? 7 : 6;
            6:  return t ? 7 : 6;
            7:  return t ? 4 : 5;
            5:  return t ? 8 : 5;
            8:  return t ? 4 : 6;
            4:  return t ? 2 : 1;
            9:  return t ? 0 : 10;
            10: return t ? 14 : 13;
            13: return t ? 14 : 13;
            14: return t ? 11 : 12;
            12: return t ? 15 : 12;
            15: return t ? 11 : 13;
            default: return t ? 2 : 1;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, longint got, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // driver: one full TCK period, pins set while TCK is low
    task automatic edge_(logic m, logic di, logic d_o);
        int nx;
        rec_t r;
        nx = ref_next(m_state, m);
        if (!m_first) exp_st.push_back(nx);
        if ((m_state == 6 || m_state == 13) && nx == m_state) begin
            if (m_cnt < BW) begin
                m_ti[m_cnt] = di; m_to[m_cnt] = d_o; m_cnt++;
            end else m_ovf = 1;
        end else if (m_state == 6 || m_state == 13) begin
            r.ir = (nx == 14); r.ti = m_ti; r.to = m_to; r.cnt = m_cnt; r.ovf = m_ovf;
            if (!stalling) exp_rec.push_back(r);
            else if (!stall_full) begin exp_rec.push_back(r); held = r; stall_full = 1; end
            m_ti = '0; m_to = '0; m_cnt = 0; m_ovf = 0;
        end
        m_state = nx;
        m_first = 0;
        tck = 1'b0; tms = m; tdi = di; tdo = d_o;
        repeat (4) @(posedge clk);
        tck = 1'b1;
        repeat (4) @(posedge clk);
        tck = 1'b0;
    endtask

    task automatic scan(bit ir, int n, logic [15:0] din, logic [15:0] dout);
        edge_(1, 0, 0);
        if (ir) edge_(1, 0, 0);
        edge_(0, 0, 0);
        edge_(0, 1, 1);
        for (int i = 0; i < n; i++) edge_(0, din[i], dout[i]);
        edge_(1, 1, 1);
        edge_(1, 0, 0);
        edge_(0, 0, 0);
    endtask

    // monitor: compare as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (st_valid) begin
                n_pulse++;
                if (exp_st.size() == 0) check(0, "R4", "unexpected report", st_code, 0);
                else begin
                    int e;
                    e = exp_st.pop_front();
                    check(st_code == 4'(e), "R3", "state code", st_code, e);
                end
            end
            if (rec_valid && rec_ready) begin
                if (exp_rec.size() == 0) check(0, "R7", "unexpected record", rec_count, 0);
                else begin
                    rec_t e;
                    e = exp_rec.pop_front();
                    check(rec_is_ir == e.ir, "R7", "record type", rec_is_ir, e.ir);
                    check(rec_tdi == e.ti, "R8", "tdi vector", rec_tdi, e.ti);
                    check(rec_tdo == e.to, "R6", "tdo vector", rec_tdo, e.to);
                    check(int'(rec_count) == e.cnt, "R9", "count", rec_count, e.cnt);
                    check(rec_ovf == e.ovf, "R9", "overflow", rec_ovf, e.ovf);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p;
        repeat (5) @(posedge clk);
        #1;
        check(st_valid == 0, "R1", "st_valid in reset", st_valid, 0);
        check(rec_valid == 0, "R1", "rec_valid in reset", rec_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(st_valid == 0 && rec_valid == 0, "R1", "idle after reset", st_valid, 0);

        // R1: start at RTI -> SDR (first, unreported) -> SIR -> TLR -> TLR -> RTI
        edge_(1, 0, 0); edge_(1, 0, 0); edge_(1, 0, 0); edge_(1, 0, 0);
        edge_(0, 0, 0); edge_(0, 0, 0);

        // R2: wiggle data pins and make a falling edge without a rise
        p = n_pulse;
        for (int i = 0; i < 6; i++) begin
            tms = i[0]; tdi = ~i[0]; tdo = i[1];
            repeat (3) @(posedge clk);
        end
        tck = 1'b0; tms = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        check(n_pulse == p, "R2", "reports while TCK idle", n_pulse, p);
        check(rec_valid == 0, "R2", "record while TCK idle", rec_valid, 0);

        // R5 R6 R8: DR scan of 5 bits, IR scan of 4 bits
        scan(0, 5, 16'b10110, 16'b01001);
        scan(1, 4, 16'b0110, 16'b1100);

        // R11: IR scan paused and resumed gives two separate records
        edge_(1, 0, 0); edge_(1, 0, 0); edge_(0, 0, 0); edge_(0, 0, 0);
        edge_(0, 1, 0); edge_(0, 1, 1); edge_(1, 0, 1);
        edge_(0, 0, 0); edge_(0, 0, 0); edge_(1, 0, 0); edge_(0, 0, 0);
        edge_(0, 0, 1); edge_(0, 1, 1); edge_(0, 0, 0);
        edge_(1, 0, 0); edge_(1, 0, 0); edge_(0, 0, 0);

        // R7: zero-bit shift, then CDR straight to E1DR (no record)
        scan(0, 0, 16'h0, 16'h0);
        edge_(1, 0, 0); edge_(0, 0, 0); edge_(1, 0, 0);
        edge_(0, 0, 0); edge_(1, 0, 0); edge_(1, 0, 0); edge_(0, 0, 0);
        check(rec_valid == 0, "R7", "record without shift", rec_valid, 0);

        // R9: exactly full, then overflowing
        scan(0, 8, 16'hA5, 16'h3C);
        scan(1, 11, 16'h5F3, 16'h2C7);

        // R10: stall the output, second record is discarded
        @(posedge clk); #1 rec_ready = 1'b0;
        stalling = 1; stall_full = 0;
        scan(0, 3, 16'b101, 16'b010);
        scan(0, 2, 16'b11, 16'b11);
        @(negedge clk);
        check(rec_valid == 1, "R10", "held valid", rec_valid, 1);
        check(rec_tdi == held.ti && int'(rec_count) == held.cnt, "R10", "held payload",
              rec_tdi, held.ti);
        @(posedge clk); #1 rec_ready = 1'b1;
        stalling = 0;
        repeat (4) @(posedge clk);
        #1;
        check(rec_valid == 0, "R10", "cleared after accept", rec_valid, 0);

        repeat (10) @(posedge clk);
        check(exp_st.size() == 0, "R4", "missing reports", exp_st.size(), 0);
        check(exp_rec.size() == 0, "R7", "missing records", exp_rec.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule